// File: doc/BRIEF.md
# Serial Configuration Command Port

This block is the slave end of a three-wire configuration link: a chip select, a serial clock driven by the host, and one data wire that carries traffic both ways. Every transaction opens with a 5-bit command from the host. After the command, either the host keeps driving data into the block or the block turns the wire around and sends read data back. Short frames carry a 16-bit word at one serial clock per bit. Long frames carry a 46-bit word and hold each bit for four serial clocks.

The block samples all three wires through synchronizers clocked by a fast system clock and detects serial-clock edges from the synchronized samples. A short write to one opcode loads a small control register. A short write to another opcode opens access to an attached one-time-programmable register controller. Once access is open, long writes raise a one-cycle strobe with the captured word and command, and long reads return the controller's word.

The frame state machine has six states. ST_IDLE holds while select is low. ST_CMD shifts in the command. ST_DECIDE spends one cycle choosing the direction and loading read data. ST_WDATA captures host data. ST_RDATA drives data out. ST_HOLD ignores further clocks until select drops. The transitions are:
- From any state to ST_IDLE when select is low.
- ST_IDLE to ST_CMD on select high.
- ST_CMD to ST_DECIDE on the fifth command rising edge.
- ST_DECIDE to ST_WDATA or ST_RDATA, according to command bit 4.
- ST_WDATA or ST_RDATA to ST_HOLD on the rising edge that closes the last data bit.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, and whenever chip select is low, the data-line enable is low and all control outputs are 0. A frame cut short by select going low has no effect.
- R2: The command is the first 5 bits after select rises, captured on serial-clock rising edges with the MSB first. Command bit 4 = 1 means write and 0 means read. Command bit 3 = 1 means long framing and 0 means short framing.
- R3: A short write of command 23 (10111) loads the control register from the data word: bit 15 to sleep_req, bit 9 to test_route, bit 8 to buf_bypass. A short read of command 7 (00111) returns these three at the same bit positions, with every other bit 0.
- R4: Bit 14 of a command-23 write gives exactly one single-cycle rst_pulse when it is 1, and none when it is 0. Bit 14 reads back as 0.
- R5: A short write of command 16 (10000) sets prog_en, which stays set until rst_n.
- R6: With prog_en set, a long write (command bits 4:3 = 11) takes 46 bits MSB first. Each bit spans 4 serial clocks and is sampled on the 4th rising edge. When the frame completes, ext_wr_stb pulses for one cycle with ext_cmd and ext_wdata holding the command and the word.
- R7: With prog_en set, a long read (bits 4:3 = 01) returns ext_rdata MSB first, with each bit held for 4 serial clocks. With prog_en clear, a long write gives no strobe and a long read returns all zeros.
- R8: On a read, sdio_oe rises after the last command rising edge and before the next one. In short framing, a new bit is presented after each rising edge, MSB first.
- R9: sdio_oe falls within 3 system clocks of chip select going low.
- R10: Unrecognised short codes change no output, and a short read of any code other than 7 returns zeros.
- R11: Serial clocks after the final bit of a frame and before select falls are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock |
| csel_i | input | 1 | Chip select, active high |
| sdio_i | input | 1 | Data wire as seen at the input buffer |
| sdio_o | output | 1 | Data driven by the block on reads |
| sdio_oe | output | 1 | Output enable for the data wire |
| ext_rdata | input | 46 | Word returned on long reads |
| sleep_req | output | 1 | Low-power request bit |
| test_route | output | 1 | Route channels to test bus |
| buf_bypass | output | 1 | Bypass output buffer |
| rst_pulse | output | 1 | One-cycle global reset pulse |
| prog_en | output | 1 | Programming access enabled |
| ext_wr_stb | output | 1 | One-cycle long-write strobe |
| ext_cmd | output | 5 | Command of the last long write |
| ext_wdata | output | 46 | Word of the last long write |

## Verification
The bound checker watches the following on every cycle:
- the output enable falls after select drops;
- the reset pulse and the long-write strobe last one cycle;
- a strobe needs programming access;
- programming access never clears;
- the control register moves only at a frame commit, and a reset pulse follows only a commit.

Only the bench's frames can show the following:
- bit ordering and the four-clock bit spacing;
- read turnaround and readback values;
- zero reads of unknown codes and of locked long reads;
- that aborted frames and extra clocks leave no trace.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DECIDE,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } ser_state_t;

    localparam int CMD_W   = 5;
    localparam int DIR_BIT = 4;
    localparam int EXT_BIT = 3;

    localparam logic [CMD_W-1:0] OPC_CFG_WR  = 5'd23;
    localparam logic [CMD_W-1:0] OPC_PROG_EN = 5'd16;
    localparam logic [CMD_W-1:0] OPC_CFG_RD  = 5'd7;

    localparam int CFG_SLEEP = 15;
    localparam int CFG_GRST  = 14;
    localparam int CFG_TEST  = 9;
    localparam int CFG_BYP   = 8;

endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], async_i[g]};
        end

        assign sync_o[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
    import cfg_serial_pkg::*;
#(
    parameter int NORM_BITS = 16,
    parameter int EXT_BITS  = 46,
    parameter int EXT_CLKS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_s,
    input  logic                cs_s,
    input  logic                sdi_s,
    input  logic [EXT_BITS-1:0] rd_word,
    output logic [CMD_W-1:0]    cmd_o,
    output logic [EXT_BITS-1:0] wdata_o,
    output logic                commit_o,
    output logic                sdo,
    output logic                sdo_oe
);

    localparam int CNT_W = $clog2(EXT_BITS + 1);
    localparam int SUB_W = (EXT_CLKS > 1) ? $clog2(EXT_CLKS) : 1;
    localparam int CC_W  = $clog2(CMD_W + 1);
    localparam int PAD   = EXT_BITS - NORM_BITS;
    localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_BITS - 1);
    localparam logic [CNT_W-1:0] EXT_LAST  = CNT_W'(EXT_BITS - 1);
    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(EXT_CLKS - 1);
    localparam logic [CC_W-1:0]  CMD_LAST  = CC_W'(CMD_W - 1);

    ser_state_t          state, state_nx;
    logic [CMD_W-1:0]    cmd_q;
    logic [CC_W-1:0]     cmd_cnt;
    logic [CNT_W-1:0]    bit_cnt;
    logic [SUB_W-1:0]    sub_cnt;
    logic [EXT_BITS-1:0] wsh, rsh;
    logic                sclk_d, oe_q, commit_q;

    logic             sclk_rise, is_ext, group_end, last_bit;
    logic [CNT_W-1:0] last_idx;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign is_ext    = cmd_q[EXT_BIT];
    assign last_idx  = is_ext ? EXT_LAST : NORM_LAST;
    assign group_end = !is_ext || (sub_cnt == SUB_LAST);
    assign last_bit  = sclk_rise && group_end && (bit_cnt == last_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!cs_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_CMD;
                ST_CMD:    if (sclk_rise && cmd_cnt == CMD_LAST) state_nx = ST_DECIDE;
                ST_DECIDE: state_nx = cmd_q[DIR_BIT] ? ST_WDATA : ST_RDATA;
                ST_WDATA:  if (last_bit) state_nx = ST_HOLD;
                ST_RDATA:  if (last_bit) state_nx = ST_HOLD;
                ST_HOLD:   state_nx = ST_HOLD;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            cmd_cnt  <= '0;
            bit_cnt  <= '0;
            sub_cnt  <= '0;
            wsh      <= '0;
            rsh      <= '0;
            sclk_d   <= 1'b0;
            oe_q     <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            sclk_d   <= sclk_s;
            commit_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cmd_cnt <= '0;
                    bit_cnt <= '0;
                    sub_cnt <= '0;
                    wsh     <= '0;
                    oe_q    <= 1'b0;
                end
                ST_CMD: begin
                    if (sclk_rise) begin
                        cmd_q   <= {cmd_q[CMD_W-2:0], sdi_s};
                        cmd_cnt <= cmd_cnt + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    rsh  <= is_ext ? rd_word : {rd_word[NORM_BITS-1:0], {PAD{1'b0}}};
                    oe_q <= !cmd_q[DIR_BIT];
                end
                ST_WDATA: begin
                    if (sclk_rise) begin
                        sub_cnt <= group_end ? '0 : sub_cnt + 1'b1;
                        if (group_end) begin
                            wsh      <= {wsh[EXT_BITS-2:0], sdi_s};
                            bit_cnt  <= bit_cnt + 1'b1;
                            commit_q <= (bit_cnt == last_idx);
                        end
                    end
                end
                ST_RDATA: begin
                    if (sclk_rise) begin
                        sub_cnt <= group_end ? '0 : sub_cnt + 1'b1;
                        if (group_end) begin
                            rsh     <= {rsh[EXT_BITS-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_HOLD: ;
                default: ;
            endcase
            if (!cs_s) oe_q <= 1'b0;
        end
    end

    assign cmd_o    = cmd_q;
    assign wdata_o  = wsh;
    assign commit_o = commit_q;
    assign sdo      = rsh[EXT_BITS-1];
    assign sdo_oe   = oe_q;

endmodule

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
    import cfg_serial_pkg::*;
#(
    parameter int NORM_BITS = 16,
    parameter int EXT_BITS  = 46
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [CMD_W-1:0]    cmd,
    input  logic [EXT_BITS-1:0] wdata,
    input  logic [EXT_BITS-1:0] ext_rdata,
    output logic [EXT_BITS-1:0] rd_word,
    output logic                sleep_req,
    output logic                test_route,
    output logic                buf_bypass,
    output logic                rst_pulse,
    output logic                prog_en,
    output logic                ext_wr_stb,
    output logic [CMD_W-1:0]    ext_cmd,
    output logic [EXT_BITS-1:0] ext_wdata
);

    logic long_op;
    assign long_op = cmd[EXT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_req  <= 1'b0;
            test_route <= 1'b0;
            buf_bypass <= 1'b0;
            rst_pulse  <= 1'b0;
            prog_en    <= 1'b0;
            ext_wr_stb <= 1'b0;
            ext_cmd    <= '0;
            ext_wdata  <= '0;
        end else begin
            rst_pulse  <= 1'b0;
            ext_wr_stb <= 1'b0;
            if (commit) begin
                if (cmd == OPC_CFG_WR) begin
                    sleep_req  <= wdata[CFG_SLEEP];
                    test_route <= wdata[CFG_TEST];
                    buf_bypass <= wdata[CFG_BYP];
                    rst_pulse  <= wdata[CFG_GRST];
                end else if (cmd == OPC_PROG_EN) begin
                    prog_en <= 1'b1;
                end else if (cmd[DIR_BIT] && long_op && prog_en) begin
                    ext_wr_stb <= 1'b1;
                    ext_cmd    <= cmd;
                    ext_wdata  <= wdata;
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (cmd == OPC_CFG_RD) begin
            rd_word[CFG_SLEEP] = sleep_req;
            rd_word[CFG_TEST]  = test_route;
            rd_word[CFG_BYP]   = buf_bypass;
        end else if (!cmd[DIR_BIT] && long_op && prog_en) begin
            rd_word = ext_rdata;
        end
    end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_serial_pkg::*;
#(
    parameter int NORM_BITS   = 16,
    parameter int EXT_BITS    = 46,
    parameter int EXT_CLKS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                csel_i,
    input  logic                sdio_i,
    output logic                sdio_o,
    output logic                sdio_oe,
    input  logic [EXT_BITS-1:0] ext_rdata,
    output logic                sleep_req,
    output logic                test_route,
    output logic                buf_bypass,
    output logic                rst_pulse,
    output logic                prog_en,
    output logic                ext_wr_stb,
    output logic [CMD_W-1:0]    ext_cmd,
    output logic [EXT_BITS-1:0] ext_wdata
);

    logic [2:0]          pins_s;
    logic                sclk_s, cs_s, sdi_s;
    logic [CMD_W-1:0]    cmd;
    logic [EXT_BITS-1:0] wdata, rd_word;
    logic                commit;

    cfg_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdio_i, csel_i, sclk_i}),
        .sync_o  (pins_s)
    );
    assign sclk_s = pins_s[0];
    assign cs_s   = pins_s[1];
    assign sdi_s  = pins_s[2];

    cfg_frame_fsm #(
        .NORM_BITS (NORM_BITS),
        .EXT_BITS  (EXT_BITS),
        .EXT_CLKS  (EXT_CLKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .cs_s     (cs_s),
        .sdi_s    (sdi_s),
        .rd_word  (rd_word),
        .cmd_o    (cmd),
        .wdata_o  (wdata),
        .commit_o (commit),
        .sdo      (sdio_o),
        .sdo_oe   (sdio_oe)
    );

    cfg_cmd_decode #(.NORM_BITS(NORM_BITS), .EXT_BITS(EXT_BITS)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .cmd        (cmd),
        .wdata      (wdata),
        .ext_rdata  (ext_rdata),
        .rd_word    (rd_word),
        .sleep_req  (sleep_req),
        .test_route (test_route),
        .buf_bypass (buf_bypass),
        .rst_pulse  (rst_pulse),
        .prog_en    (prog_en),
        .ext_wr_stb (ext_wr_stb),
        .ext_cmd    (ext_cmd),
        .ext_wdata  (ext_wdata)
    );

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic commit,
    input logic sdio_oe,
    input logic rst_pulse,
    input logic ext_wr_stb,
    input logic prog_en,
    input logic sleep_req,
    input logic test_route,
    input logic buf_bypass
);

    AST_OE_DROPS_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !sdio_oe); // R9

    AST_GRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse); // R4

    AST_GRST_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $past(commit)); // R4

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_stb |=> !ext_wr_stb); // R6

    AST_STB_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_stb |-> $past(prog_en)); // R7

    AST_PROG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> prog_en); // R5

    AST_CFG_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({sleep_req, test_route, buf_bypass})); // R3

endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .commit     (commit),
    .sdio_oe    (sdio_oe),
    .rst_pulse  (rst_pulse),
    .ext_wr_stb (ext_wr_stb),
    .prog_en    (prog_en),
    .sleep_req  (sleep_req),
    .test_route (test_route),
    .buf_bypass (buf_bypass)
);

// File: tb/cfg_serial_port_test.sv
`timescale 1ns/1ps
module cfg_serial_port_test;

    logic        clk = 0, rst_n = 0;
    logic        sclk = 0, csel = 0, sdi = 0;
    logic        sdo, sdo_oe;
    logic [45:0] ext_rdata = '0;
    logic        sleep_req, test_route, buf_bypass, rst_pulse, prog_en, ext_wr_stb;
    logic [4:0]  ext_cmd;
    logic [45:0] ext_wdata;

    int checks = 0, errors = 0;
    int rst_seen = 0, stb_seen = 0;
    logic m_sleep = 0, m_test = 0, m_byp = 0, m_prog = 0;
    int exp_rst = 0, exp_stb = 0;

    always #2.5 clk = ~clk;

    cfg_serial_port uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csel_i(csel), .sdio_i(sdi),
        .sdio_o(sdo), .sdio_oe(sdo_oe), .ext_rdata(ext_rdata),
        .sleep_req(sleep_req), .test_route(test_route), .buf_bypass(buf_bypass),
        .rst_pulse(rst_pulse), .prog_en(prog_en), .ext_wr_stb(ext_wr_stb),
        .ext_cmd(ext_cmd), .ext_wdata(ext_wdata)
    );

    always @(posedge clk) begin
        if (rst_pulse)  rst_seen++;
        if (ext_wr_stb) stb_seen++;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk();
        wait_clk(4);
        sclk = 1;
        wait_clk(4);
        sclk = 0;
    endtask

    function automatic logic [45:0] exp_read(input logic [4:0] c, input logic [45:0] xv);
        if (c == 5'd7) return {30'b0, m_sleep, 5'b0, m_test, m_byp, 8'b0};
        if (!c[4] && c[3] && m_prog) return xv;
        return '0;
    endfunction

    task automatic model_write(input logic [4:0] c, input logic [45:0] d);
        if (c == 5'd23) begin
            m_sleep = d[15]; m_test = d[9]; m_byp = d[8];
            if (d[14]) exp_rst++;
        end else if (c == 5'd16) begin
            m_prog = 1;
        end else if (c[4] && c[3] && m_prog) begin
            exp_stb++;
        end
    endtask

    // full frame; abort_after >= 0 drops select after that many data bits
    task automatic xfer(input logic [4:0] c, input logic [45:0] wd, input int extra,
                        input int abort_after, output logic [45:0] rd);
        int n, cpb;
        n   = c[3] ? 46 : 16;
        cpb = c[3] ? 4 : 1;
        rd  = '0;
        csel = 1;
        wait_clk(4);
        for (int i = 4; i >= 0; i--) begin
            sdi = c[i];
            pulse_sclk();
        end
        sdi = 0;
        for (int b = n - 1; b >= 0; b--) begin
            if (abort_after >= 0 && (n - 1 - b) == abort_after) break;
            for (int k = 0; k < cpb; k++) begin
                if (c[4]) sdi = wd[b];
                wait_clk(4);
                if (!c[4] && k == cpb - 1) begin
                    rd[b] = sdo;
                    if (b == n - 1) check("R8 oe during read", sdo_oe, 1);
                end
                sclk = 1;
                wait_clk(4);
                sclk = 0;
            end
        end
        for (int e = 0; e < extra; e++) begin
            sdi = 1;
            pulse_sclk();
        end
        wait_clk(6);
        csel = 0;
        wait_clk(3);
        check("R9 oe off after select low", sdo_oe, 0);
        wait_clk(3);
    endtask

    task automatic check_state(input string tag);
        check({tag, " sleep_req"}, sleep_req, m_sleep);
        check({tag, " test_route"}, test_route, m_test);
        check({tag, " buf_bypass"}, buf_bypass, m_byp);
        check({tag, " prog_en"}, prog_en, m_prog);
        check({tag, " rst pulses"}, rst_seen, exp_rst);
        check({tag, " strobes"}, stb_seen, exp_stb);
    endtask

    task automatic do_write(input string tag, input logic [4:0] c, input logic [45:0] d);
        logic [45:0] rd;
        xfer(c, d, 0, -1, rd);
        model_write(c, d);
        check_state(tag);
        if (c[4] && c[3] && m_prog) begin
            check({tag, " R6 ext_cmd"}, ext_cmd, c);
            check({tag, " R6 ext_wdata"}, ext_wdata, d);
        end
    endtask

    task automatic do_read(input string tag, input logic [4:0] c, input logic [45:0] xv);
        logic [45:0] rd;
        ext_rdata = xv;
        xfer(c, '0, 0, -1, rd);
        check(tag, rd, exp_read(c, xv));
        check_state(tag);
    endtask

    initial begin
        logic [45:0] rd, rv;
        logic [4:0] c;
        int kind;
        void'($urandom(32'h5EED_0042));
        wait_clk(5);
        check("R1 oe after reset", sdo_oe, 0);
        check("R1 outputs after reset", {sleep_req, test_route, buf_bypass, rst_pulse, prog_en, ext_wr_stb}, 0);
        rst_n = 1;
        wait_clk(5);

        do_write("R3 cfg write all ones", 5'd23, 46'h0000_0000_FFFF);
        do_read ("R3 cfg readback", 5'd7, '0);
        do_write("R4 cfg write no grst", 5'd23, 46'h0000_0000_8100);
        do_read ("R4 grst not stored R2", 5'd7, '0);
        do_read ("R7 locked long read", 5'b01111, 46'h2AAA_5555_1234);
        do_write("R7 locked long write", 5'b11111, 46'h1234_5678_9ABC);
        do_write("R10 unknown short write", 5'd21, 46'h0000_0000_0000);
        do_read ("R10 unknown short read", 5'd3, '0);

        // R1: aborted frame has no effect
        xfer(5'd23, 46'h0000_0000_4000, 0, 8, rd);
        check_state("R1 aborted frame");

        // R11: extra clocks after a complete frame
        xfer(5'd23, 46'h0000_0000_0200, 5, -1, rd);
        model_write(5'd23, 46'h0000_0000_0200);
        check_state("R11 extra clocks");

        do_write("R5 prog enable", 5'd16, '0);
        do_write("R6 long write", 5'b11001, 46'h2DEA_DBEE_F123);
        do_read ("R7 long read", 5'b01111, 46'h3FFF_0000_A5A5);
        do_read ("R7 long read alt", 5'b01001, 46'h1555_5555_5555);

        for (int it = 0; it < 30; it++) begin
            kind = $urandom % 5;
            rv = {$urandom, $urandom};
            c  = 5'($urandom);
            unique case (kind)
                0: do_write("R3 random cfg write", 5'd23, {30'b0, rv[15:0]});
                1: do_read ("R3 random cfg read", 5'd7, rv);
                2: do_write("R6 random long write", {2'b11, c[2:0]}, rv);
                3: do_read ("R7 random long read", {2'b01, c[2:0]}, rv);
                default: begin
                    if (c == 5'd23 || c == 5'd16 || c == 5'd7 || c[3]) c = 5'd20;
                    if (c[4]) do_write("R10 random unknown write", c, {30'b0, rv[15:0]});
                    else      do_read ("R10 random unknown read", c, rv);
                end
            endcase
        end

        rst_n = 0;
        wait_clk(3);
        check("R5 prog_en cleared by reset", prog_en, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule